// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one input-capture lane of a general-purpose timer. An asynchronous pin is brought into the clock domain, cleaned by a digital filter that only accepts a level after it has been seen for a programmable number of samples, and turned into rising and falling edge pulses. A two-bit polarity code picks which of those edges forms the lane's trigger. That trigger is exported for a slave controller, along with a raw pulse for every edge of the filtered input.

A source selector decides what counts as a capture event. The choices are the lane's own trigger, the filtered edges of the neighbouring lane (put through this lane's polarity choice), or an internal trigger pulse from a slave controller. The events are thinned by a /1, /2, /4 or /8 prescaler. On each event that the prescaler passes, the lane copies the free-running counter value, supplied as an input, into its capture register and sets a capture flag. A capture that arrives while that flag is still set also raises an overcapture flag. The counter, the compare stage and any register bus sit outside the block.

Top module: `tmr_capture_chan`

## Requirements
- R1: With filter code 0 the pin goes through a two-flop synchronizer and one filter register. A pin change driven before clock edge k shows on `edge_any` in the cycle after edge k+2, and not before.
- R2: With a non-zero filter code F, the filtered level changes only after 2·F consecutive sample ticks that disagree with it. With F=2 and a sample tick every cycle, a 3-cycle pin pulse is rejected and a 6-cycle pulse is accepted.
- R3: Polarity code 00 selects rising edges, 01 falling edges and 11 both edges. Code 10 behaves as rising. The result drives `own_trig`.
- R4: `edge_any` pulses on every rising and every falling edge of the filtered pin, whatever the polarity code.
- R5: Source code 01 captures on `own_trig`. Code 10 captures on the polarity-selected `nb_rise`/`nb_fall`. Code 11 captures on `itr_in`. Code 00 captures nothing.
- R6: Prescaler code P (0..3) makes a capture happen on every 2^P-th selected event.
- R7: While `cap_en` is 0, events are neither counted nor captured. Clearing `cap_en` or changing `psc` returns the prescaler count to zero.
- R8: On a capture, `cap_val` takes the value `cnt_in` had at that clock edge, and `cap_flag` is set.
- R9: A capture while `cap_flag` is already 1 sets `ovr_flag`.
- R10: `clr_cap` clears `cap_flag` and `clr_ovr` clears `ovr_flag`. A capture in the same cycle as `clr_cap` leaves `cap_flag` set.
- R11: After reset, `cap_val` is 0, both flags are 0 and no edge output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous capture pin |
| smp_tick | input | 1 | Filter sample enable, derived from the sampling clock |
| filt_cfg | input | 4 | Filter code; 0 bypasses the filter |
| pol | input | 2 | Edge polarity code |
| src_sel | input | 2 | Capture source code |
| psc | input | 2 | Event prescaler code |
| cap_en | input | 1 | Capture enable |
| nb_rise | input | 1 | Rising edge pulse of the neighbouring lane's filtered input |
| nb_fall | input | 1 | Falling edge pulse of the neighbouring lane's filtered input |
| itr_in | input | 1 | Internal trigger pulse from the slave controller |
| cnt_in | input | CW | Free-running counter value |
| clr_cap | input | 1 | Clear pulse for the capture flag |
| clr_ovr | input | 1 | Clear pulse for the overcapture flag |
| own_rise | output | 1 | Rising edge pulse of the filtered pin, for the neighbour |
| own_fall | output | 1 | Falling edge pulse of the filtered pin, for the neighbour |
| own_trig | output | 1 | Polarity-selected edge pulse |
| edge_any | output | 1 | Pulse on either edge of the filtered pin |
| cap_evt | output | 1 | Capture strobe |
| cap_val | output | CW | Capture register |
| cap_flag | output | 1 | Capture flag |
| ovr_flag | output | 1 | Overcapture flag |

## Verification
Several rules are checked by the assertions on every cycle. The filtered level only ever moves toward the synchronized sample. Rising and falling pulses never coincide, and a trigger pulse always sits on a real edge. The prescaler count stays below its divisor. No capture happens while the lane is disabled or set to code 00, and every capture leaves the sampled counter value and a set flag, plus the overcapture flag when it applies. Only the bench's scenarios can show the rest: the exact synchronizer latency, the glitch length the filter rejects, which edges each polarity code picks, the event counts per prescaler code, and the prescaler restart after a disable or a code change.

// File: rtl/cap_pkg.sv
package cap_pkg;

  // Number of disagreeing samples needed before the filtered level flips.
  function automatic logic [4:0] filt_len(input logic [3:0] cfg);
    if (cfg == 4'd0) filt_len = 5'd1;
    else             filt_len = {cfg, 1'b0};
  endfunction

  // Event divisor for a prescaler code.
  function automatic logic [3:0] presc_div(input logic [1:0] code);
    presc_div = 4'd1 << code;
  endfunction

  // Pick edges according to the polarity code (10 treated as rising).
  function automatic logic pick_edge(input logic [1:0] p, input logic r, input logic f);
    case (p)
      2'b01:   pick_edge = f;
      2'b11:   pick_edge = r | f;
      default: pick_edge = r;
    endcase
  endfunction

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_OWN  = 2'b01,
    SRC_NB   = 2'b10,
    SRC_ITR  = 2'b11
  } src_e;

endpackage

// File: rtl/cap_sync_filter.sv
module cap_sync_filter
  import cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FCFG_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin,
  input  logic              smp_tick,
  input  logic [FCFG_W-1:0] cfg,
  output logic              filt_o
);
  localparam int CNT_W = FCFG_W + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_out;
  logic [CNT_W-1:0]       run_cnt;
  logic [CNT_W-1:0]       need_m1;
  logic                   mismatch;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[gi] <= 1'b0;
        else if (gi == 0) sync_q[gi] <= pin;
        else sync_q[gi] <= sync_q[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  assign sync_out = sync_q[SYNC_STAGES-1];
  assign need_m1  = filt_len(cfg) - 1'b1;
  assign mismatch = (sync_out != filt_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_o  <= 1'b0;
      run_cnt <= '0;
    end else if (cfg == '0) begin
      filt_o  <= sync_out;
      run_cnt <= '0;
    end else if (smp_tick) begin
      if (!mismatch) begin
        run_cnt <= '0;
      end else if (run_cnt >= need_m1) begin
        filt_o  <= sync_out;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // The filtered level may only move to the value the synchronizer held.
  assert_filt_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_o != $past(filt_o)) |-> (filt_o == $past(sync_out)));

endmodule

// File: rtl/cap_edge_pol.sv
module cap_edge_pol
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       filt_i,
  input  logic [1:0] pol,
  output logic       rise_o,
  output logic       fall_o,
  output logic       any_o,
  output logic       trig_o
);
  logic filt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_d <= 1'b0;
    else        filt_d <= filt_i;
  end

  assign rise_o = filt_i & ~filt_d;
  assign fall_o = ~filt_i & filt_d;
  assign any_o  = filt_i ^ filt_d;
  assign trig_o = pick_edge(pol, rise_o, fall_o);

  assert_edge_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));
  assert_any_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (filt_i != $past(filt_i)));
  assert_trig_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> any_o);

endmodule

// File: rtl/cap_prescaler.sv
module cap_prescaler
  import cap_pkg::*;
#(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_i,
  input  logic             en_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             fire_o
);
  localparam int MAX_DIV = 1 << ((1 << PSC_W) - 1);
  localparam int CNT_W   = $clog2(MAX_DIV) + 1;

  logic [CNT_W-1:0] ev_cnt;
  logic [PSC_W-1:0] psc_q;
  logic             restart;
  logic [CNT_W-1:0] last_idx;

  assign restart  = !en_i || (psc_i != psc_q);
  assign last_idx = CNT_W'(presc_div(psc_i)) - 1'b1;
  assign fire_o   = !restart && ev_i && (ev_cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_cnt <= '0;
      psc_q  <= '0;
    end else begin
      psc_q <= psc_i;
      if (restart)      ev_cnt <= '0;
      else if (fire_o)  ev_cnt <= '0;
      else if (ev_i)    ev_cnt <= ev_cnt + 1'b1;
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cnt < CNT_W'(presc_div(psc_q)));
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> (ev_cnt == '0));

endmodule

// File: rtl/tmr_capture_chan.sv
module tmr_capture_chan
  import cap_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_in,
  input  logic          smp_tick,
  input  logic [3:0]    filt_cfg,
  input  logic [1:0]    pol,
  input  logic [1:0]    src_sel,
  input  logic [1:0]    psc,
  input  logic          cap_en,
  input  logic          nb_rise,
  input  logic          nb_fall,
  input  logic          itr_in,
  input  logic [CW-1:0] cnt_in,
  input  logic          clr_cap,
  input  logic          clr_ovr,
  output logic          own_rise,
  output logic          own_fall,
  output logic          own_trig,
  output logic          edge_any,
  output logic          cap_evt,
  output logic [CW-1:0] cap_val,
  output logic          cap_flag,
  output logic          ovr_flag
);
  logic filt_lvl;
  logic nb_trig;
  logic sel_evt;
  logic lane_on;

  cap_sync_filter #(.SYNC_STAGES(2), .FCFG_W(4)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin(pin_in), .smp_tick(smp_tick),
    .cfg(filt_cfg), .filt_o(filt_lvl)
  );

  cap_edge_pol u_edge (
    .clk(clk), .rst_n(rst_n), .filt_i(filt_lvl), .pol(pol),
    .rise_o(own_rise), .fall_o(own_fall), .any_o(edge_any), .trig_o(own_trig)
  );

  assign nb_trig = pick_edge(pol, nb_rise, nb_fall);

  always_comb begin
    case (src_e'(src_sel))
      SRC_OWN: sel_evt = own_trig;
      SRC_NB:  sel_evt = nb_trig;
      SRC_ITR: sel_evt = itr_in;
      default: sel_evt = 1'b0;
    endcase
  end

  assign lane_on = cap_en && (src_sel != SRC_NONE);

  cap_prescaler #(.PSC_W(2)) u_psc (
    .clk(clk), .rst_n(rst_n), .ev_i(sel_evt), .en_i(lane_on),
    .psc_i(psc), .fire_o(cap_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_val  <= '0;
      cap_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (cap_evt) cap_val <= cnt_in;
      if (cap_evt)      cap_flag <= 1'b1;
      else if (clr_cap) cap_flag <= 1'b0;
      if (cap_evt && cap_flag) ovr_flag <= 1'b1;
      else if (clr_ovr)        ovr_flag <= 1'b0;
    end
  end

  assert_no_cap_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> (cap_en && src_sel != 2'b00));
  assert_cap_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_flag && cap_val == $past(cnt_in)));
  assert_ovr_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && cap_flag) |=> ovr_flag);
  assert_hold_val_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_val));

endmodule

// File: tb/tb_tmr_capture_chan.sv
module tb_tmr_capture_chan;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_in = 1'b0, smp_tick = 1'b1;
  logic [3:0] filt_cfg = 4'd0;
  logic [1:0] pol = 2'b00, src_sel = 2'b01, psc = 2'b00;
  logic cap_en = 1'b1, nb_rise = 1'b0, nb_fall = 1'b0, itr_in = 1'b0;
  logic [CW-1:0] cnt_in = '0;
  logic clr_cap = 1'b0, clr_ovr = 1'b0;
  logic own_rise, own_fall, own_trig, edge_any, cap_evt, cap_flag, ovr_flag;
  logic [CW-1:0] cap_val;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_capture_chan #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .smp_tick(smp_tick),
    .filt_cfg(filt_cfg), .pol(pol), .src_sel(src_sel), .psc(psc),
    .cap_en(cap_en), .nb_rise(nb_rise), .nb_fall(nb_fall), .itr_in(itr_in),
    .cnt_in(cnt_in), .clr_cap(clr_cap), .clr_ovr(clr_ovr),
    .own_rise(own_rise), .own_fall(own_fall), .own_trig(own_trig),
    .edge_any(edge_any), .cap_evt(cap_evt), .cap_val(cap_val),
    .cap_flag(cap_flag), .ovr_flag(ovr_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    clr_cap = 1'b1; clr_ovr = 1'b1;
    wait_n(1);
    clr_cap = 1'b0; clr_ovr = 1'b0;
  endtask

  task automatic pin_pulse(input int width, input int gap);
    pin_in = 1'b1; wait_n(width);
    pin_in = 1'b0; wait_n(gap);
  endtask

  task automatic nb_pulse();
    nb_rise = 1'b1; wait_n(1);
    nb_rise = 1'b0; wait_n(1);
  endtask

  task automatic t_reset();
    check(cap_val == 0, "R11 cap_val", cap_val, 0);
    check(!cap_flag && !ovr_flag, "R11 flags", {cap_flag, ovr_flag}, 0);
    check(!edge_any && !own_trig, "R11 edges", {edge_any, own_trig}, 0);
  endtask

  task automatic t_bypass();
    filt_cfg = 0; pol = 2'b00; src_sel = 2'b01; psc = 0; cap_en = 1;
    cnt_in = 16'd100;
    pin_in = 1'b1;
    wait_n(2);
    check(edge_any == 1'b0, "R1 early", edge_any, 0);
    wait_n(1);
    check(edge_any == 1'b1, "R1 edge_any", edge_any, 1);
    check(own_trig == 1'b1, "R3 rising trig", own_trig, 1);
    wait_n(1);
    check(cap_flag == 1'b1, "R8 flag", cap_flag, 1);
    check(cap_val == 100, "R8 value", cap_val, 100);
    pin_in = 1'b0; wait_n(6);
    clear_flags();
  endtask

  task automatic t_filter();
    filt_cfg = 4'd2; cnt_in = 16'd200;
    wait_n(2);
    pin_pulse(3, 12);
    check(cap_flag == 1'b0, "R2 glitch rejected", cap_flag, 0);
    pin_pulse(6, 12);
    check(cap_flag == 1'b1, "R2 pulse accepted", cap_flag, 1);
    check(cap_val == 200, "R2 value", cap_val, 200);
    filt_cfg = 4'd0; wait_n(2);
    clear_flags();
  endtask

  task automatic t_polarity();
    for (int p = 0; p < 4; p++) begin
      pol = 2'(p); src_sel = 2'b01; psc = 0;
      cnt_in = 16'(300 + p);
      clear_flags();
      pin_in = 1'b1; wait_n(8);
      check(cap_flag == (p != 1), "R3 rise capture", cap_flag, (p != 1));
      clear_flags();
      pin_in = 1'b0;
      wait_n(3);
      check(edge_any == 1'b1, "R4 fall edge_any", edge_any, 1);
      wait_n(5);
      check(cap_flag == (p == 1 || p == 3), "R3 fall capture", cap_flag, (p == 1 || p == 3));
    end
    pol = 2'b00;
    clear_flags();
  endtask

  task automatic t_source();
    psc = 0; pol = 2'b00;
    src_sel = 2'b10; cnt_in = 16'd410;
    clear_flags();
    pin_pulse(6, 8);
    check(cap_flag == 1'b0, "R5 nb ignores pin", cap_flag, 0);
    nb_pulse();
    check(cap_flag == 1'b1 && cap_val == 410, "R5 nb capture", cap_val, 410);
    src_sel = 2'b11; cnt_in = 16'd420;
    clear_flags();
    nb_pulse();
    check(cap_flag == 1'b0, "R5 itr ignores nb", cap_flag, 0);
    itr_in = 1'b1; wait_n(1); itr_in = 1'b0; wait_n(1);
    check(cap_flag == 1'b1 && cap_val == 420, "R5 itr capture", cap_val, 420);
    src_sel = 2'b00; cnt_in = 16'd430;
    clear_flags();
    nb_pulse();
    itr_in = 1'b1; wait_n(1); itr_in = 1'b0; wait_n(1);
    pin_pulse(6, 8);
    check(cap_flag == 1'b0 && cap_val == 420, "R5 code 00 no capture", cap_val, 420);
  endtask

  task automatic t_presc();
    src_sel = 2'b10; pol = 2'b00;
    for (int p = 0; p < 4; p++) begin
      psc = 2'(p); wait_n(2);
      clear_flags();
      cnt_in = 16'(500 + p);
      for (int k = 0; k < (1 << p) - 1; k++) nb_pulse();
      check(cap_flag == 1'b0, "R6 before Nth event", cap_flag, 0);
      nb_pulse();
      check(cap_flag == 1'b1 && cap_val == 500 + p, "R6 Nth event", cap_val, 500 + p);
    end
    psc = 0; wait_n(1);
    clear_flags();
  endtask

  task automatic t_enable();
    src_sel = 2'b10; psc = 0; cnt_in = 16'd600;
    clear_flags();
    cap_en = 1'b0;
    nb_pulse();
    check(cap_flag == 1'b0, "R7 disabled no flag", cap_flag, 0);
    check(cap_val != 600, "R7 disabled no latch", cap_val, 0);
    psc = 2'd1; wait_n(1);
    cap_en = 1'b1; wait_n(1);
    nb_pulse();
    cap_en = 1'b0; wait_n(1);
    cap_en = 1'b1; wait_n(1);
    nb_pulse();
    check(cap_flag == 1'b0, "R7 disable restarts count", cap_flag, 0);
    nb_pulse();
    check(cap_flag == 1'b1, "R7 count after restart", cap_flag, 1);
    clear_flags();
    nb_pulse();
    psc = 2'd2; wait_n(1);
    psc = 2'd1; wait_n(1);
    nb_pulse();
    check(cap_flag == 1'b0, "R7 psc change restarts", cap_flag, 0);
    nb_pulse();
    check(cap_flag == 1'b1, "R7 capture after psc change", cap_flag, 1);
    psc = 0; wait_n(1);
    clear_flags();
  endtask

  task automatic t_flags();
    src_sel = 2'b10; psc = 0;
    clear_flags();
    cnt_in = 16'd700; nb_pulse();
    check(ovr_flag == 1'b0, "R9 no overcapture yet", ovr_flag, 0);
    cnt_in = 16'd701; nb_pulse();
    check(ovr_flag == 1'b1 && cap_val == 701, "R9 overcapture", ovr_flag, 1);
    clr_ovr = 1'b1; wait_n(1); clr_ovr = 1'b0;
    check(ovr_flag == 1'b0 && cap_flag == 1'b1, "R10 clr_ovr only", {cap_flag, ovr_flag}, 2);
    clr_cap = 1'b1; wait_n(1); clr_cap = 1'b0;
    check(cap_flag == 1'b0, "R10 clr_cap", cap_flag, 0);
    clr_cap = 1'b1; nb_rise = 1'b1; wait_n(1);
    clr_cap = 1'b0; nb_rise = 1'b0; wait_n(1);
    check(cap_flag == 1'b1, "R10 capture beats clear", cap_flag, 1);
    check(ovr_flag == 1'b0, "R9 no overcapture after clear", ovr_flag, 0);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_bypass();
    t_filter();
    t_polarity();
    t_source();
    t_presc();
    t_enable();
    t_flags();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule